// File: doc/BRIEF.md
# Module clock enable and idle status manager

This block sits beside one peripheral module and decides when its clocks run. Software writes a two-bit mode: 0 turns the module off and 2 turns it on; the values 1 and 3 are reserved and a write that carries one of them leaves the mode as it was. When the mode changes, the block runs a request/acknowledge idle handshake with the module. It reports progress through a two-bit idle status and a one-bit standby status.

While the module is off, any bus access aimed at it is answered with an error, unless that access is flagged as wakeup traffic that started asynchronously. When the module is on, its functional clock is held on. Its interface clock may be stopped whenever the clock domain asks for this. A set of optional functional clock enables is written by software and drives the clock-enable outputs directly.

Two resets are used. The cold reset clears everything. The warm reset clears only the software-written fields, so the status fields and the handshake state live through it.

Top module: `modclk_mgr`

## Requirements
- R1: After a cold reset the mode reads 0, the idle status reads 3, the standby status reads 1, the idle request is high, all optional enables are 0, and both the functional and the interface clock enables are 0.
- R2: A write with mode value 1 or 3 leaves the mode and the idle status unchanged.
- R3: Writing mode 2 while off drops the idle request. The idle status reads 1 from the cycle after the mode updates, and stays at 1 until the module lowers its idle acknowledge. In the cycle after that it reads 0.
- R4: Writing mode 0 while on raises the idle request. The idle status reads 1, and the functional clock stays enabled, until the module raises its idle acknowledge. In the cycle after that the status reads 3 and both clock enables are 0.
- R5: Writing mode 2 during a sleep transition aborts it. The idle request drops, the status stays 1, and the status returns to 0 once the acknowledge is low.
- R6: When the status is 0 or 2, the functional clock enable is 1. If the domain interface-gate input is high, the status reads 2 and the interface clock enable is 0. Otherwise the status reads 0 and the interface clock enable is 1.
- R7: The bus error output is high exactly when a bus request is present, the status is 3, and the wakeup flag is low.
- R8: Every write loads the optional enable bits, which appear unchanged on the optional clock-enable outputs. This holds even when the mode value in the write is reserved.
- R9: A warm reset clears the mode and the optional enables but leaves the idle status and the standby status unchanged. The handshake then proceeds toward off.
- R10: The standby status equals the module standby input sampled one cycle earlier.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_cold_n | input | 1 | Cold reset, active low, synchronous; clears all state |
| rst_warm_n | input | 1 | Warm reset, active low, synchronous; clears software fields only |
| cfg_we | input | 1 | Write strobe for mode and optional enables |
| cfg_mode | input | 2 | Mode value to write (0 off, 2 on, 1/3 reserved) |
| cfg_opt | input | N_OPT | Optional clock enable bits to write |
| mod_idle_ack | input | 1 | Idle acknowledge from the module |
| mod_stby | input | 1 | Standby indication from the module |
| dom_iclk_gate | input | 1 | Domain asks for the interface clock to stop |
| bus_req | input | 1 | Bus access targeting the module |
| bus_wakeup | input | 1 | Current access is asynchronous wakeup traffic |
| mode_st | output | 2 | Current mode |
| opt_clk_en | output | N_OPT | Optional functional clock enables |
| idle_req | output | 1 | Idle request to the module |
| fclk_en | output | 1 | Functional clock enable |
| iclk_en | output | 1 | Interface clock enable |
| idle_st | output | 2 | Idle status: 0 on, 1 in transition, 2 interface idle, 3 off |
| stby_st | output | 1 | Standby status |
| bus_err | output | 1 | Error response for the current access |

## Verification
The hardest case to reach is the sleep abort. The mode must be rewritten to 2 after the sleep transition has begun, while the module is still holding its acknowledge low. The stimulus enables the module, writes mode 0, waits one cycle so the idle request is visibly high, and only then writes mode 2 with the acknowledge still low. The warm reset is applied while the module is on with optional enables set. This shows that the status survives the reset and that the block then walks the handshake toward off.

// File: rtl/modclk_mgr.sv
module modclk_mgr #(
  parameter int N_OPT = 6
) (
  input  logic             clk,
  input  logic             rst_cold_n,
  input  logic             rst_warm_n,
  input  logic             cfg_we,
  input  logic [1:0]       cfg_mode,
  input  logic [N_OPT-1:0] cfg_opt,
  input  logic             mod_idle_ack,
  input  logic             mod_stby,
  input  logic             dom_iclk_gate,
  input  logic             bus_req,
  input  logic             bus_wakeup,
  output logic [1:0]       mode_st,
  output logic [N_OPT-1:0] opt_clk_en,
  output logic             idle_req,
  output logic             fclk_en,
  output logic             iclk_en,
  output logic [1:0]       idle_st,
  output logic             stby_st,
  output logic             bus_err
);
  localparam logic [1:0] MODE_OFF = 2'd0;
  localparam logic [1:0] MODE_ON  = 2'd2;

  typedef enum logic [1:0] {S_OFF, S_WAKE, S_ON, S_SLEEP} state_t;

  state_t state_q, state_d;
  logic [1:0]       mode_q;
  logic [N_OPT-1:0] opt_q;
  logic             stby_q;

  wire sw_rst   = !rst_cold_n || !rst_warm_n;
  wire mode_ok  = (cfg_mode == MODE_OFF) || (cfg_mode == MODE_ON);

  always_ff @(posedge clk) begin
    if (sw_rst) begin
      mode_q <= MODE_OFF;
      opt_q  <= '0;
    end else if (cfg_we) begin
      opt_q <= cfg_opt;
      if (mode_ok) mode_q <= cfg_mode;
    end
  end

  always_comb begin
    state_d = state_q;
    case (state_q)
      S_OFF:   if (mode_q == MODE_ON) state_d = S_WAKE;
      S_WAKE:  if (mode_q == MODE_OFF) state_d = S_SLEEP;
               else if (!mod_idle_ack) state_d = S_ON;
      S_ON:    if (mode_q == MODE_OFF) state_d = S_SLEEP;
      S_SLEEP: if (mode_q == MODE_ON) state_d = S_WAKE;
               else if (mod_idle_ack) state_d = S_OFF;
      default: state_d = S_OFF;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_cold_n) begin
      state_q <= S_OFF;
      stby_q  <= 1'b1;
    end else begin
      state_q <= state_d;
      stby_q  <= mod_stby;
    end
  end

  assign mode_st    = mode_q;
  assign opt_clk_en = opt_q;
  assign stby_st    = stby_q;
  assign idle_req   = (state_q == S_OFF) || (state_q == S_SLEEP);
  assign fclk_en    = (state_q != S_OFF);
  assign iclk_en    = fclk_en && !((state_q == S_ON) && dom_iclk_gate);
  assign bus_err    = bus_req && !bus_wakeup && (state_q == S_OFF);

  always_comb begin
    case (state_q)
      S_OFF:   idle_st = 2'd3;
      S_ON:    idle_st = dom_iclk_gate ? 2'd2 : 2'd0;
      default: idle_st = 2'd1;
    endcase
  end
endmodule

module modclk_mgr_chk (
  input logic       clk,
  input logic       rst_cold_n,
  input logic       rst_warm_n,
  input logic       cfg_we,
  input logic [1:0] cfg_mode,
  input logic       mod_idle_ack,
  input logic       mod_stby,
  input logic       bus_req,
  input logic       bus_wakeup,
  input logic [1:0] mode_st,
  input logic       idle_req,
  input logic       fclk_en,
  input logic       iclk_en,
  input logic [1:0] idle_st,
  input logic       stby_st,
  input logic       bus_err
);
  // R7
  err_only_when_off_chk: assert property (@(posedge clk) disable iff (!rst_cold_n)
    bus_err |-> (idle_st == 2'd3) && bus_req && !bus_wakeup);

  // R2
  reserved_mode_kept_chk: assert property (@(posedge clk) disable iff (!rst_cold_n || !rst_warm_n)
    (cfg_we && cfg_mode[0]) |=> (mode_st == $past(mode_st)));

  // R3
  wake_waits_ack_chk: assert property (@(posedge clk) disable iff (!rst_cold_n)
    (idle_st == 2'd1 && !idle_req && mod_idle_ack && mode_st == 2'd2) |=> (idle_st == 2'd1));

  // R4
  sleep_waits_ack_chk: assert property (@(posedge clk) disable iff (!rst_cold_n)
    (idle_st == 2'd1 && idle_req && !mod_idle_ack && mode_st == 2'd0) |=> (idle_st == 2'd1 && fclk_en));

  // R1
  off_clocks_stopped_chk: assert property (@(posedge clk) disable iff (!rst_cold_n)
    (idle_st == 2'd3) |-> (!fclk_en && !iclk_en && idle_req));

  // R6
  on_fclk_running_chk: assert property (@(posedge clk) disable iff (!rst_cold_n)
    (idle_st == 2'd0 || idle_st == 2'd2) |-> fclk_en);

  // R10
  stby_follow_chk: assert property (@(posedge clk) disable iff (!rst_cold_n)
    1'b1 |=> (stby_st == $past(mod_stby)));
endmodule

bind modclk_mgr modclk_mgr_chk u_chk (
  .clk(clk), .rst_cold_n(rst_cold_n), .rst_warm_n(rst_warm_n),
  .cfg_we(cfg_we), .cfg_mode(cfg_mode), .mod_idle_ack(mod_idle_ack),
  .mod_stby(mod_stby), .bus_req(bus_req), .bus_wakeup(bus_wakeup),
  .mode_st(mode_st), .idle_req(idle_req), .fclk_en(fclk_en),
  .iclk_en(iclk_en), .idle_st(idle_st), .stby_st(stby_st), .bus_err(bus_err)
);

// File: tb/modclk_mgr_bench.sv
module modclk_mgr_bench;
  localparam int N_OPT = 6;
  localparam int NV = 4;

  logic clk = 1'b0;
  logic rst_cold_n = 1'b0, rst_warm_n = 1'b1;
  logic cfg_we = 1'b0;
  logic [1:0] cfg_mode = 2'd0;
  logic [N_OPT-1:0] cfg_opt = '0;
  logic mod_idle_ack = 1'b1, mod_stby = 1'b1, dom_iclk_gate = 1'b0;
  logic bus_req = 1'b0, bus_wakeup = 1'b0;
  logic [1:0] mode_st, idle_st;
  logic [N_OPT-1:0] opt_clk_en;
  logic idle_req, fclk_en, iclk_en, stby_st, bus_err;

  int checks = 0, errors = 0;
  logic done = 1'b0;

  always #10 clk = ~clk;

  modclk_mgr #(.N_OPT(N_OPT)) u_modclk_mgr (
    .clk(clk), .rst_cold_n(rst_cold_n), .rst_warm_n(rst_warm_n),
    .cfg_we(cfg_we), .cfg_mode(cfg_mode), .cfg_opt(cfg_opt),
    .mod_idle_ack(mod_idle_ack), .mod_stby(mod_stby),
    .dom_iclk_gate(dom_iclk_gate), .bus_req(bus_req), .bus_wakeup(bus_wakeup),
    .mode_st(mode_st), .opt_clk_en(opt_clk_en), .idle_req(idle_req),
    .fclk_en(fclk_en), .iclk_en(iclk_en), .idle_st(idle_st),
    .stby_st(stby_st), .bus_err(bus_err)
  );

  // row: {gate, req, wakeup, exp_err, exp_idle[1:0], exp_iclk}
  localparam logic [6:0] VEC [NV] = '{
    7'b0_0_0_0_00_1,
    7'b1_0_0_0_10_0,
    7'b0_1_0_0_00_1,
    7'b1_1_1_0_10_0
  };

  task automatic tick();
    @(posedge clk); #1;
  endtask

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] m, input logic [N_OPT-1:0] o);
    cfg_we = 1'b1; cfg_mode = m; cfg_opt = o;
    tick();
    cfg_we = 1'b0;
  endtask

  initial begin
    #(20 * 100000);
    errors++;
    $display("FAIL watchdog actual 0 expected 1");
    if (!done) begin
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) tick();
    rst_cold_n = 1'b1;
    tick();
    chk("R1 mode", mode_st, 0);
    chk("R1 idle", idle_st, 3);
    chk("R1 stby", stby_st, 1);
    chk("R1 req", idle_req, 1);
    chk("R1 opt", opt_clk_en, 0);
    chk("R1 clks", {fclk_en, iclk_en}, 0);

    bus_req = 1'b1; #1;
    chk("R7 err off", bus_err, 1);
    bus_wakeup = 1'b1; #1;
    chk("R7 wakeup no err", bus_err, 0);
    bus_req = 1'b0; bus_wakeup = 1'b0;

    wr(2'd1, 6'b101001);
    chk("R2 mode 1 ignored", mode_st, 0);
    chk("R8 opt load", opt_clk_en, 6'b101001);
    wr(2'd3, 6'b101001);
    tick();
    chk("R2 mode 3 ignored", mode_st, 0);
    chk("R2 idle kept", idle_st, 3);

    wr(2'd2, 6'b101001);
    chk("R3 mode set", mode_st, 2);
    chk("R3 idle before fsm", idle_st, 3);
    tick();
    chk("R3 transit", idle_st, 1);
    chk("R3 req low", idle_req, 0);
    chk("R3 fclk", fclk_en, 1);
    tick();
    chk("R3 still transit", idle_st, 1);
    mod_idle_ack = 1'b0;
    tick();
    chk("R3 on", idle_st, 0);

    for (int i = 0; i < NV; i++) begin
      {dom_iclk_gate, bus_req, bus_wakeup} = VEC[i][6:4];
      #1;
      chk("R7 err on", bus_err, VEC[i][3]);
      chk("R6 idle", idle_st, VEC[i][2:1]);
      chk("R6 iclk", iclk_en, VEC[i][0]);
      chk("R6 fclk", fclk_en, 1);
    end
    dom_iclk_gate = 1'b0; bus_req = 1'b0; bus_wakeup = 1'b0;

    mod_stby = 1'b0;
    tick();
    chk("R10 stby low", stby_st, 0);

    wr(2'd0, 6'b101001);
    tick();
    chk("R4 transit", idle_st, 1);
    chk("R4 req", idle_req, 1);
    chk("R4 fclk held", fclk_en, 1);
    tick();
    chk("R4 still transit", idle_st, 1);
    mod_idle_ack = 1'b1;
    tick();
    chk("R4 off", idle_st, 3);
    chk("R4 clks off", {fclk_en, iclk_en}, 0);

    wr(2'd2, 6'b000111);
    tick();
    mod_idle_ack = 1'b0;
    tick();
    chk("R5 on again", idle_st, 0);
    wr(2'd0, 6'b000111);
    tick();
    chk("R5 sleeping", idle_req, 1);
    wr(2'd2, 6'b000111);
    tick();
    chk("R5 abort transit", idle_st, 1);
    chk("R5 abort req low", idle_req, 0);
    tick();
    chk("R5 back on", idle_st, 0);

    rst_warm_n = 1'b0;
    tick();
    rst_warm_n = 1'b1;
    chk("R9 mode cleared", mode_st, 0);
    chk("R9 opt cleared", opt_clk_en, 0);
    chk("R9 idle kept", idle_st, 0);
    chk("R9 stby kept", stby_st, 0);
    tick();
    chk("R9 heading off", idle_st, 1);
    mod_idle_ack = 1'b1;
    tick();
    chk("R9 off", idle_st, 3);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule